// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Edge Interrupts

This block is a general-purpose I/O port with eight pins, one bit per pin in every register. A small byte-wide register port sets each pin's direction, the value it drives when it is an output, and which edges on the pin raise an interrupt. Reading the port register returns the driven value for output pins and the synchronized pad level for input pins. All pins share a single interrupt line.

Each pin can be set to detect a rising edge, a falling edge, or both, and it has its own interrupt enable. Each pad input passes through a two-flop synchronizer before the edge detector. When an enabled pin sees a selected edge, a sticky status bit is set for that pin. Software clears status bits by writing ones to a separate acknowledge register. The shared interrupt output stays high while any status bit is set.

The register port is a plain strobe interface with no back-pressure. A write takes effect on the clock edge where `wr_en` is high. Read data is combinational and valid in the same cycle as `rd_en`. No stream interface is involved.

Top module: `gpio_edge_port`

## Requirements
- R1: Reset is asynchronous and active low, and it clears every register. After reset all pins are inputs (`pin_oe` = 0), `pin_out` = 0, `irq` = 0, and every register reads 0.
- R2: A write to offset 0 loads the port register. `pin_out` shows the new value right after that clock edge and changes at no other time.
- R3: Offset 6 holds the direction register. Bit value 1 makes the pin an output and 0 makes it an input. `pin_oe` mirrors this register and changes only when offset 6 is written.
- R4: A read of offset 0 returns, per bit, the port register bit for output pins and the synchronized pad level for input pins. A pad change becomes visible on the second rising clock edge after it is applied.
- R5: Offset 4 selects rising-edge detection per pin. For an enabled pin, a 0-to-1 pad change sets that pin's bit in the status register (offset 2) on the third clock edge after the change.
- R6: Offset 5 selects falling-edge detection per pin. A pin with both selects set latches on either edge. A pin with only the rising select ignores a falling edge.
- R7: Offset 1 is the interrupt enable register. An edge on a pin whose enable bit is 0 does not set status. Setting the enable later does not set status for edges that were already missed.
- R8: `irq` is high exactly when at least one status bit is set.
- R9: Writing offset 3 clears each status bit whose data bit is 1 and leaves the other status bits unchanged. A read of offset 3 always returns 0.
- R10: If a qualifying edge latches on a pin in the same clock edge as an acknowledge for that pin, the status bit stays set.
- R11: Writes to the status register at offset 2 are ignored. A read of offset 7 (unmapped) returns 0.
- R12: `rd_data` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wr_data | input | 8 | Write data, one bit per pin |
| rd_data | output | 8 | Read data, valid in the `rd_en` cycle |
| pin_in | input | 8 | Asynchronous pad levels |
| pin_out | output | 8 | Values driven toward the pads |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Combined port interrupt |

## Verification
Two functions can land on the same clock edge: an acknowledge write clearing a pin's status bit, and a newly detected edge on that pin setting it again. The bench first gets a pin's status latched. It then toggles that pin and places the acknowledge write so that its clock edge is exactly the third edge after the toggle, the edge where the new event latches. The result is judged by a status read returning the bit still set and `irq` staying high. A plain acknowledge afterwards must then clear the bit.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_PORT = 3'd0,
    SEL_IEN  = 3'd1,
    SEL_IST  = 3'd2,
    SEL_ACK  = 3'd3,
    SEL_RISE = 3'd4,
    SEL_FALL = 3'd5,
    SEL_DIR  = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_now,
  output logic [NPINS-1:0] pin_rise,
  output logic [NPINS-1:0] pin_fall
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][NPINS-1:0] chain_q;
  logic [NPINS-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q[0] <= pin_in;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[LAST];
    end
  end

  assign pin_now  = chain_q[LAST];
  assign pin_rise = pin_now & ~prev_q;
  assign pin_fall = ~pin_now & prev_q;
endmodule

// File: rtl/gpio_irq_latch.sv
module gpio_irq_latch #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_rise,
  input  logic [NPINS-1:0] pin_fall,
  input  logic [NPINS-1:0] ien,
  input  logic [NPINS-1:0] rise_sel,
  input  logic [NPINS-1:0] fall_sel,
  input  logic [NPINS-1:0] ack_mask,
  output logic [NPINS-1:0] status,
  output logic             irq
);
  logic [NPINS-1:0] hit;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign hit[i] = ien[i] & ((pin_rise[i] & rise_sel[i]) | (pin_fall[i] & fall_sel[i]));
  end

  // A new hit wins over an acknowledge in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~ack_mask) | hit;
  end

  assign irq = |status;
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]      wr_data,
  input  logic [NPINS-1:0]      pin_now,
  input  logic [NPINS-1:0]      status,
  output logic [NPINS-1:0]      port_q,
  output logic [NPINS-1:0]      dir_q,
  output logic [NPINS-1:0]      ien_q,
  output logic [NPINS-1:0]      rise_q,
  output logic [NPINS-1:0]      fall_q,
  output logic [NPINS-1:0]      ack_mask,
  output logic [NPINS-1:0]      rd_data
);
  reg_sel_e         sel;
  logic [NPINS-1:0] pin_view;
  logic [NPINS-1:0] rd_mux;

  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_PORT: port_q <= wr_data;
        SEL_IEN:  ien_q  <= wr_data;
        SEL_RISE: rise_q <= wr_data;
        SEL_FALL: fall_q <= wr_data;
        SEL_DIR:  dir_q  <= wr_data;
        default:  ;
      endcase
    end
  end

  assign ack_mask = (wr_en && sel == SEL_ACK) ? wr_data : '0;
  assign pin_view = (dir_q & port_q) | (~dir_q & pin_now);

  always_comb begin
    case (sel)
      SEL_PORT: rd_mux = pin_view;
      SEL_IEN:  rd_mux = ien_q;
      SEL_IST:  rd_mux = status;
      SEL_RISE: rd_mux = rise_q;
      SEL_FALL: rd_mux = fall_q;
      SEL_DIR:  rd_mux = dir_q;
      default:  rd_mux = '0;
    endcase
  end

  assign rd_data = rd_en ? rd_mux : '0;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]      wr_data,
  output logic [NPINS-1:0]      rd_data,
  input  logic [NPINS-1:0]      pin_in,
  output logic [NPINS-1:0]      pin_out,
  output logic [NPINS-1:0]      pin_oe,
  output logic                  irq
);
  logic [NPINS-1:0] pin_now, pin_rise, pin_fall;
  logic [NPINS-1:0] port_q, dir_q, ien_q, rise_q, fall_q, ack_mask;
  logic [NPINS-1:0] irq_status;

  gpio_pin_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .pin_now(pin_now), .pin_rise(pin_rise), .pin_fall(pin_fall)
  );

  gpio_reg_bank #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .pin_now(pin_now), .status(irq_status),
    .port_q(port_q), .dir_q(dir_q), .ien_q(ien_q), .rise_q(rise_q),
    .fall_q(fall_q), .ack_mask(ack_mask), .rd_data(rd_data)
  );

  gpio_irq_latch #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .pin_rise(pin_rise), .pin_fall(pin_fall),
    .ien(ien_q), .rise_sel(rise_q), .fall_sel(fall_q), .ack_mask(ack_mask),
    .status(irq_status), .irq(irq)
  );

  assign pin_out = port_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [REG_ADDR_W-1:0] addr,
  input logic [NPINS-1:0]      wr_data,
  input logic [NPINS-1:0]      rd_data,
  input logic [NPINS-1:0]      pin_out,
  input logic [NPINS-1:0]      pin_oe,
  input logic                  irq,
  input logic [NPINS-1:0]      status,
  input logic [NPINS-1:0]      int_en
);
  p_reset_clears_r1: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0 && irq == 1'b0));

  p_dout_only_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_out) |-> $past(wr_en && addr == SEL_PORT));

  p_dir_only_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe) |-> $past(wr_en && addr == SEL_DIR));

  p_new_status_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~$past(status) & ~$past(int_en)) == '0);

  p_irq_drop_needs_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en && addr == SEL_ACK && wr_data != '0));

  p_ack_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == SEL_ACK) |-> rd_data == '0);

  p_idle_bus_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq(irq), .status(irq_status), .int_en(ien_q)
);

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data, pin_in = '0, pin_out, pin_oe;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit model_on = 1'b0, finished = 1'b0;

  always #5 clk = ~clk;

  gpio_edge_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Reference model state
  logic [7:0] m_port, m_dir, m_ien, m_rise, m_fall, m_st;
  logic [7:0] hist[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return (m_dir & m_port) | (~m_dir & hist[1]);
      3'd1: return m_ien;
      3'd2: return m_st;
      3'd4: return m_rise;
      3'd5: return m_fall;
      3'd6: return m_dir;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_port = 0; m_dir = 0; m_ien = 0; m_rise = 0; m_fall = 0; m_st = 0;
      hist = '{8'h00, 8'h00, 8'h00};
    end else begin
      logic [7:0] nw, od, ev, ack;
      nw  = hist[1];
      od  = hist[2];
      ev  = m_ien & ((nw & ~od & m_rise) | (~nw & od & m_fall));
      ack = (wr_en && addr == 3'd3) ? wr_data : 8'h00;
      m_st = (m_st & ~ack) | ev;
      if (wr_en) begin
        case (addr)
          3'd0: m_port = wr_data;
          3'd1: m_ien  = wr_data;
          3'd4: m_rise = wr_data;
          3'd5: m_fall = wr_data;
          3'd6: m_dir  = wr_data;
          default: ;
        endcase
      end
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  // Per-cycle comparison against the model, away from the clock edge
  always begin
    @(negedge clk);
    #4;
    if (model_on && rst_n) begin
      chk("R2 model pin_out", pin_out, m_port);
      chk("R3 model pin_oe", pin_oe, m_dir);
      chk("R8 model irq", irq, (m_st != 0));
      chk("R12 model rd_data", rd_data, rd_en ? m_read(addr) : 8'h00);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    #4 chk(tag, rd_data, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    model_on = 1'b1;
    // R1 reset state
    #4 chk("R1 pin_oe after reset", pin_oe, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 pin_out after reset", pin_out, 0);
    @(negedge clk);
    for (int a = 0; a < 8; a++) rd_chk(a[2:0], 8'h00, "R1 register reads zero");

    // R2 / R3 / R4 direction and data
    pin_in = 8'h03;
    wr(3'd6, 8'hF0);
    wr(3'd0, 8'hA5);
    #4 chk("R2 pin_out", pin_out, 8'hA5);
    chk("R3 pin_oe", pin_oe, 8'hF0);
    @(negedge clk);
    idle(2);
    rd_chk(3'd0, 8'hA3, "R4 mixed read");

    // R4 synchronizer latency
    pin_in = 8'h0C; rd_en = 1'b1; addr = 3'd0;
    #4 chk("R4 before first edge", rd_data, 8'hA3);
    @(negedge clk); #4 chk("R4 after one edge", rd_data, 8'hA3);
    @(negedge clk); #4 chk("R4 after two edges", rd_data, 8'hAC);
    @(negedge clk); rd_en = 1'b0;

    // R5 rising edge latency
    wr(3'd1, 8'hFF);
    wr(3'd4, 8'h01);
    pin_in = 8'h0D;
    #4 chk("R5 irq at change", irq, 0);
    @(negedge clk); #4 chk("R5 irq after edge 1", irq, 0);
    @(negedge clk); #4 chk("R5 irq after edge 2", irq, 0);
    @(negedge clk); #4 chk("R5 irq after edge 3", irq, 1);
    @(negedge clk);
    rd_chk(3'd2, 8'h01, "R5 status");

    // R6 falling and both edges, R9 selective ack
    wr(3'd4, 8'h03);
    wr(3'd5, 8'h02);
    pin_in = 8'h0F; idle(4);
    rd_chk(3'd2, 8'h03, "R6 both-select pin rising");
    wr(3'd3, 8'h02);
    rd_chk(3'd2, 8'h01, "R9 other bits untouched");
    pin_in = 8'h0D; idle(4);
    rd_chk(3'd2, 8'h03, "R6 falling latched");
    wr(3'd3, 8'h03);
    #4 chk("R9 irq cleared", irq, 0);
    @(negedge clk);
    rd_chk(3'd2, 8'h00, "R9 status cleared");
    pin_in = 8'h0C; idle(4);
    rd_chk(3'd2, 8'h00, "R6 rise-only pin ignores fall");

    // R7 masking
    wr(3'd1, 8'hFE);
    pin_in = 8'h0D; idle(4);
    rd_chk(3'd2, 8'h00, "R7 disabled pin ignored");
    #4 chk("R7 irq stays low", irq, 0);
    @(negedge clk);
    wr(3'd1, 8'hFF); idle(4);
    rd_chk(3'd2, 8'h00, "R7 no late latch");

    // R10 collision of new edge and acknowledge
    pin_in = 8'h0F; idle(4);
    rd_chk(3'd2, 8'h02, "R10 setup status");
    pin_in = 8'h0D;
    @(negedge clk);
    @(negedge clk);
    wr(3'd3, 8'h02);
    rd_chk(3'd2, 8'h02, "R10 edge beats ack");
    #4 chk("R10 irq held", irq, 1);
    @(negedge clk);
    wr(3'd3, 8'h02);
    rd_chk(3'd2, 8'h00, "R10 later ack clears");

    // R11 status not writable, unmapped read
    pin_in = 8'h0F; idle(4);
    wr(3'd2, 8'h00);
    rd_chk(3'd2, 8'h02, "R11 status write ignored");
    rd_chk(3'd7, 8'h00, "R11 unmapped reads zero");
    rd_chk(3'd3, 8'h00, "R9 ack reads zero");
    #4 chk("R8 irq with pending", irq, 1);
    @(negedge clk);
    wr(3'd3, 8'hFF);
    #4 chk("R8 irq after clear", irq, 0);
    @(negedge clk);

    // R12 read port
    addr = 3'd4;
    #4 chk("R12 idle read zero", rd_data, 0);
    @(negedge clk);
    rd_chk(3'd4, 8'h03, "R12 rise select read");
    rd_chk(3'd5, 8'h02, "R12 fall select read");
    rd_chk(3'd1, 8'hFF, "R12 enable read");
    rd_chk(3'd6, 8'hF0, "R12 direction read");

    // R1 asynchronous reset mid-run
    model_on = 1'b0;
    rst_n = 1'b0;
    #4 chk("R1 pin_oe async reset", pin_oe, 0);
    chk("R1 pin_out async reset", pin_out, 0);
    chk("R1 irq async reset", irq, 0);
    idle(2);
    summary();
  end
endmodule